// File: doc/BRIEF.md
# ADC Parallel Read Sequencer

This block is the host-side controller for an eight-channel, 14-bit converter that samples all of its inputs at the same instant and returns the results over a parallel bus. After the chip reset is released, it sends the converter a reset pulse of fixed length. It then waits for a start request. When the request arrives, it raises both conversion-start lines together. It follows the converter's busy handshake through a synchroniser. Once busy falls, it opens a chip-select frame and issues one read strobe per result.

Two read modes are available. In word mode, each strobe returns a whole 14-bit result. In byte mode, each result arrives as two bytes on the low eight data lines. The controller counts the low and high phase of every read strobe in system clocks; these counts come from input ports and have lower bounds. The converter drives a first-data marker, which should be high only on the very first read. The controller checks it on every read, using the synchronised value. If the marker is wrong, the controller flags the error, deselects the converter and restarts the read frame from channel 0. Each completed result is output with its channel index, as a two's-complement value sign-extended to 16 bits.

Top module: `adc_par_seq`

## Requirements
- R1: After `rst_n` is released, `adc_reset` is high for exactly RST_CYC consecutive clock cycles, starting at the first clock edge. While it is high, `adc_cs_n` and `adc_rd_n` stay high and both conversion-start lines stay low.
- R2: A `start` pulse that arrives while the block is idle and the synchronised busy is low drives `adc_convst_a` and `adc_convst_b` high in the same cycle. Both lines stay high until the synchronised busy is seen high, and then both return low.
- R3: A `start` that arrives while busy is high is discarded, and so is a `start` that arrives while a conversion or read is in progress. A discarded `start` is not remembered. No conversion-start line ever rises while busy is high.
- R4: `adc_cs_n` falls only after the synchronised busy has fallen. One frame issues 8 read strobes in word mode (`byte_mode`=0) or 16 in byte mode (`byte_mode`=1). `adc_cs_n` returns high after the last strobe.
- R5: Each low phase of `adc_rd_n` lasts max(`rd_low_cyc`, 3) clocks. Each high phase inside a frame lasts max(`rd_high_cyc`, 1) clocks. This includes the setup time between the fall of `adc_cs_n` and the first strobe.
- R6: In word mode, the result for read k is `adc_db[13:0]` as sampled in the last low cycle of that read, and it is reported with channel index k (0 to 7).
- R7: In byte mode, reads 2c and 2c+1 form channel c. Bits [5:0] of the first byte become result bits [13:8], and all eight bits of the second byte become bits [7:0]. `adc_db[13:8]` and bits [7:6] of the first byte are ignored.
- R8: Every result is reported as a single-cycle `res_valid` pulse. `res_chan` carries the channel index and `res_data` carries the result sign-extended from bit 13 to 16 bits.
- R9: The synchronised marker must be 1 on the first read of a frame and 0 on every later read. On a mismatch, the controller discards that read and pulses `align_err` for one cycle. It then holds `adc_cs_n` high for the high-phase count and restarts the frame from read 0, without a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request pulse |
| byte_mode | input | 1 | 1 selects two 8-bit reads per result |
| rd_low_cyc | input | 8 | Read strobe low time in clocks (minimum 3 applied) |
| rd_high_cyc | input | 8 | Read strobe high time in clocks (minimum 1 applied) |
| adc_reset | output | 1 | Reset pulse to the converter |
| adc_convst_a | output | 1 | Conversion start, first channel group |
| adc_convst_b | output | 1 | Conversion start, second channel group |
| adc_busy | input | 1 | Converter busy flag (asynchronous) |
| adc_frst | input | 1 | First-data marker from the converter (asynchronous) |
| adc_db | input | 14 | Converter parallel data bus |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rd_n | output | 1 | Active-low read strobe |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 3 | Channel index of the result |
| res_data | output | 16 | Sign-extended result |
| align_err | output | 1 | Marker mismatch pulse |

## Verification
The assertions assume the following of the converter. Busy rises while the start lines are high. Data and marker are settled by the end of every read low phase. The read timing counts and `byte_mode` change only while the block is idle.

The bench keeps within these limits with a behavioural converter model that runs on the falling clock edge. The model raises busy one half-cycle after it sees a start edge and presents each read's data half a cycle after the strobe falls. The stimulus changes the mode and the timing counts only between frames. The marker is corrupted only on the first frame after a conversion, which lets the restarted frame finish cleanly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_TRIG,
      ST_CONV,
      ST_HIGH,
      ST_LOW,
      ST_RECOVER
   } seq_state_t;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_seq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else if (i == 0) stg[i] <= d;
         else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_seq_assemble.sv
module adc_seq_assemble #(
   parameter int RES_W = 14,
   parameter int OUT_W = 16,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             byte_mode,
   input  logic             second_half,
   input  logic [CH_W-1:0]  chan_in,
   input  logic [RES_W-1:0] db,
   output logic             valid,
   output logic [CH_W-1:0]  chan,
   output logic [OUT_W-1:0] data
);

   localparam int HI_W = RES_W - 8;

   if (RES_W <= 8 || RES_W > 16 || OUT_W < RES_W) begin : g_bad_width
      $error("adc_seq_assemble: need 8 < RES_W <= 16 and OUT_W >= RES_W");
   end

   logic [HI_W-1:0]  hi_q;
   logic [RES_W-1:0] full;
   logic [OUT_W-1:0] ext;
   logic             last;

   always_comb begin
      full = byte_mode ? {hi_q, db[7:0]} : db;
      last = !byte_mode || second_half;
   end

   if (OUT_W > RES_W) begin : g_sext
      assign ext = {{(OUT_W-RES_W){full[RES_W-1]}}, full};
   end else begin : g_flat
      assign ext = full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         chan  <= '0;
         data  <= '0;
         hi_q  <= '0;
      end else begin
         valid <= take && last;
         if (take && byte_mode && !second_half) hi_q <= db[HI_W-1:0];
         if (take && last) begin
            chan <= chan_in;
            data <= ext;
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R8

endmodule

// File: rtl/adc_par_seq.sv
module adc_par_seq #(
   parameter int CH_N        = 8,
   parameter int RES_W       = 14,
   parameter int OUT_W       = 16,
   parameter int CNT_W       = 8,
   parameter int RST_CYC     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    byte_mode,
   input  logic [CNT_W-1:0]        rd_low_cyc,
   input  logic [CNT_W-1:0]        rd_high_cyc,
   output logic                    adc_reset,
   output logic                    adc_convst_a,
   output logic                    adc_convst_b,
   input  logic                    adc_busy,
   input  logic                    adc_frst,
   input  logic [RES_W-1:0]        adc_db,
   output logic                    adc_cs_n,
   output logic                    adc_rd_n,
   output logic                    res_valid,
   output logic [$clog2(CH_N)-1:0] res_chan,
   output logic [OUT_W-1:0]        res_data,
   output logic                    align_err
);
   import adc_seq_pkg::*;

   localparam int CH_W     = $clog2(CH_N);
   localparam int IDX_W    = CH_W + 2;
   localparam int RCW      = $clog2(RST_CYC + 1);
   localparam int MIN_LOW  = SYNC_STAGES + 1;
   localparam int MIN_HIGH = 1;

   if (RST_CYC < 1 || CH_N < 2 || (1 << CH_W) != CH_N || MIN_LOW >= (1 << CNT_W)) begin : g_bad_cfg
      $error("adc_par_seq: illegal parameter set");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] cnt, lo_eff, hi_eff;
   logic [IDX_W-1:0] idx, n_reads;
   logic [RCW-1:0]   rst_cnt;
   logic             rst_pulse, convst_q, busy_s, frst_s;
   logic             lo_end, hi_end, mark_ok, take;
   logic [CH_W-1:0]  chan_sel;

   adc_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({adc_busy, adc_frst}),
      .q    ({busy_s, frst_s})
   );

   always_comb begin
      lo_eff   = (rd_low_cyc  < CNT_W'(MIN_LOW))  ? CNT_W'(MIN_LOW)  : rd_low_cyc;
      hi_eff   = (rd_high_cyc < CNT_W'(MIN_HIGH)) ? CNT_W'(MIN_HIGH) : rd_high_cyc;
      n_reads  = byte_mode ? IDX_W'(2*CH_N) : IDX_W'(CH_N);
      lo_end   = (cnt == lo_eff - 1'b1);
      hi_end   = (cnt == hi_eff - 1'b1);
      mark_ok  = (frst_s == (idx == '0));
      take     = (state == ST_LOW) && lo_end && mark_ok;
      chan_sel = byte_mode ? idx[CH_W:1] : idx[CH_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_BOOT;
         rst_cnt   <= '0;
         rst_pulse <= 1'b0;
         convst_q  <= 1'b0;
         cnt       <= '0;
         idx       <= '0;
         align_err <= 1'b0;
      end else begin
         align_err <= 1'b0;
         case (state)
            ST_BOOT: begin
               if (rst_cnt == RCW'(RST_CYC)) begin
                  rst_pulse <= 1'b0;
                  state     <= ST_IDLE;
               end else begin
                  rst_pulse <= 1'b1;
                  rst_cnt   <= rst_cnt + 1'b1;
               end
            end
            ST_IDLE: begin
               if (start && !busy_s) begin
                  convst_q <= 1'b1;
                  state    <= ST_TRIG;
               end
            end
            ST_TRIG: begin
               if (busy_s) begin
                  convst_q <= 1'b0;
                  state    <= ST_CONV;
               end
            end
            ST_CONV: begin
               if (!busy_s) begin
                  cnt   <= '0;
                  idx   <= '0;
                  state <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (hi_end) begin
                  cnt   <= '0;
                  state <= (idx == n_reads) ? ST_IDLE : ST_LOW;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_LOW: begin
               if (lo_end) begin
                  cnt <= '0;
                  if (!mark_ok) begin
                     align_err <= 1'b1;
                     idx       <= '0;
                     state     <= ST_RECOVER;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_HIGH;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RECOVER: begin
               if (hi_end) begin
                  cnt   <= '0;
                  state <= ST_HIGH;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign adc_reset    = rst_pulse;
   assign adc_convst_a = convst_q;
   assign adc_convst_b = convst_q;
   assign adc_cs_n     = !((state == ST_HIGH) || (state == ST_LOW));
   assign adc_rd_n     = (state != ST_LOW);

   adc_seq_assemble #(.RES_W(RES_W), .OUT_W(OUT_W), .CH_W(CH_W)) i_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .byte_mode  (byte_mode),
      .second_half(idx[0]),
      .chan_in    (chan_sel),
      .db         (adc_db),
      .valid      (res_valid),
      .chan       (res_chan),
      .data       (res_data)
   );

   AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      adc_reset |-> (adc_cs_n && adc_rd_n && !adc_convst_a)); // R1
   AST_CONV_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_convst_a) |-> !busy_s); // R3
   AST_FRAME_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> !busy_s); // R4
   AST_RD_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rd_n) |=> (!adc_rd_n ##1 !adc_rd_n)); // R5
   AST_ERR_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> (adc_cs_n && !res_valid)); // R9

endmodule

// File: tb/test_adc_par_seq.sv
module test_adc_par_seq;

   localparam int RST_CYC  = 3;
   localparam int CONV_CYC = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        byte_mode = 1'b0;
   logic [7:0]  rd_low_cyc = 8'd3;
   logic [7:0]  rd_high_cyc = 8'd1;
   logic        adc_reset, adc_convst_a, adc_convst_b, adc_cs_n, adc_rd_n;
   logic        res_valid, align_err;
   logic [2:0]  res_chan;
   logic [15:0] res_data;
   logic        adc_busy, adc_frst;
   logic [13:0] adc_db;

   logic busy_m = 1'b0, busy_force = 1'b0;
   assign adc_busy = busy_m | busy_force;

   int checks = 0, fails = 0, cyc = 0;
   int cur_seed = 0, err_mode = 0, attempts = 0, got = 0, nerr = 0, exp_ch = 0;
   int exp_lo = 3, exp_hi = 1, lo_w = 0, hi_w = 0, conv_cnt = 0, ptr = 0;
   logic p_cs = 1'b1, p_rd = 1'b1, p_cv = 1'b0;
   logic frst_q = 1'b0;
   logic [13:0] db_q = '0;
   assign adc_frst = frst_q;
   assign adc_db   = db_q;

   always #10 clk = ~clk;

   adc_par_seq i_adc_par_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
      .rd_low_cyc(rd_low_cyc), .rd_high_cyc(rd_high_cyc),
      .adc_reset(adc_reset), .adc_convst_a(adc_convst_a), .adc_convst_b(adc_convst_b),
      .adc_busy(adc_busy), .adc_frst(adc_frst), .adc_db(adc_db),
      .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .res_valid(res_valid),
      .res_chan(res_chan), .res_data(res_data), .align_err(align_err)
   );

   function automatic logic [13:0] word_of(int s, int ch);
      if (s == 0) begin
         case (ch)
            0: return 14'h1FFF;  1: return 14'h2000;  2: return 14'h0000;
            3: return 14'h3FFF;  4: return 14'h0001;  5: return 14'h3FFE;
            6: return 14'h1000;  default: return 14'h2AAA;
         endcase
      end
      return 14'((s*1109 + ch*2731 + s*ch*37) & 16383);
   endfunction

   function automatic logic [15:0] sext_of(logic [13:0] w);
      int v = int'(w);
      if (v >= 8192) v = v - 16384;
      return 16'(v);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Behavioural converter and output monitor, on the falling clock edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "watchdog", cyc, 150000);
         finish_run();
      end
      if (adc_reset) begin
         busy_m = 1'b0; conv_cnt = 0;
      end
      if (adc_convst_a && !p_cv) begin
         chk(adc_convst_b == 1'b1, "R2 convst lines together", int'(adc_convst_b), 1);
         chk(adc_busy == 1'b0, "R3 start edge while busy", int'(adc_busy), 0);
         if (!busy_m) begin busy_m = 1'b1; conv_cnt = CONV_CYC; end
      end else if (busy_m) begin
         conv_cnt--;
         if (conv_cnt == 0) busy_m = 1'b0;
      end
      if (!adc_cs_n && p_cs) begin
         chk(adc_busy == 1'b0, "R4 frame opened while busy", int'(adc_busy), 0);
         ptr = 0; attempts++; hi_w = 1;
      end else if (!adc_cs_n && !adc_rd_n && p_rd) begin
         chk(hi_w == exp_hi, "R5 high phase", hi_w, exp_hi);
         lo_w = 1;
         begin
            logic [13:0] w;
            w = word_of(cur_seed, byte_mode ? ptr / 2 : ptr);
            if (!byte_mode) db_q = w;
            else if ((ptr % 2) == 0) db_q = {6'h2A, 2'b11, w[13:8]};
            else db_q = {6'h15, w[7:0]};
            frst_q = (ptr == 0);
            if (err_mode == 1 && attempts == 1 && ptr == 0) frst_q = 1'b0;
            if (err_mode == 2 && attempts == 1 && ptr == 3) frst_q = 1'b1;
         end
         ptr++;
      end else if (!adc_rd_n) begin
         lo_w++;
      end else if (adc_rd_n && !p_rd) begin
         chk(lo_w == exp_lo, "R5 low phase", lo_w, exp_lo);
         hi_w = 1;
      end else if (!adc_cs_n) begin
         hi_w++;
      end
      if (adc_cs_n && !p_cs) frst_q = 1'b0;
      if (align_err) begin
         nerr++; exp_ch = 0;
      end
      if (res_valid) begin
         chk(int'(res_chan) == exp_ch, "R6/R7 channel order", int'(res_chan), exp_ch);
         chk(res_data == sext_of(word_of(cur_seed, int'(res_chan))),
             byte_mode ? "R7 byte assembly R8" : "R6 word result R8",
             int'(res_data), int'(sext_of(word_of(cur_seed, int'(res_chan)))));
         exp_ch++; got++;
      end
      p_cs = adc_cs_n; p_rd = adc_rd_n; p_cv = adc_convst_a;
   end

   task automatic run_trial(input bit bm, input int lo, input int hi, input int em, input int seed);
      int exp_got;
      @(negedge clk);
      byte_mode = bm; rd_low_cyc = 8'(lo); rd_high_cyc = 8'(hi);
      exp_lo = (lo < 3) ? 3 : lo;
      exp_hi = (hi < 1) ? 1 : hi;
      cur_seed = seed; err_mode = em; attempts = 0; got = 0; nerr = 0; exp_ch = 0;
      exp_got = 8;
      if (em == 2) exp_got = bm ? 9 : 11;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (got < exp_got || !adc_cs_n || busy_m) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(got == exp_got, "R4 results per frame", got, exp_got);
      chk(nerr == ((em != 0) ? 1 : 0), "R9 alignment errors", nerr, (em != 0) ? 1 : 0);
      chk(adc_cs_n == 1'b1, "R4 frame closed", int'(adc_cs_n), 1);
   endtask

   initial begin
      int hcount;
      repeat (4) @(negedge clk);
      chk(adc_reset == 1'b0 && res_valid == 1'b0, "R1 quiet in reset", int'(adc_reset), 0);
      rst_n = 1'b1;
      hcount = 0;
      @(negedge clk);
      while (adc_reset) begin
         chk(adc_cs_n && adc_rd_n && !adc_convst_a, "R1 strobes idle during pulse",
             int'({adc_cs_n, adc_rd_n, adc_convst_a}), 6);
         hcount++;
         @(negedge clk);
      end
      chk(hcount == RST_CYC, "R1 reset pulse width", hcount, RST_CYC);

      // R3: start while busy is discarded and not remembered
      busy_force = 1'b1;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      chk(adc_convst_a == 1'b0 && adc_cs_n == 1'b1, "R3 start ignored while busy", int'(adc_convst_a), 0);
      busy_force = 1'b0;
      repeat (12) @(negedge clk);
      chk(adc_convst_a == 1'b0 && got == 0, "R3 ignored start not remembered", int'(adc_convst_a), 0);

      // Extremes of the signed range in both modes
      run_trial(1'b0, 3, 1, 0, 0);
      run_trial(1'b1, 3, 1, 0, 0);

      // Sweep of modes and strobe timings, R5 clamps included
      begin
         int s = 1;
         for (int bm = 0; bm < 2; bm++)
            for (int li = 0; li < 4; li++)
               for (int hi = 0; hi < 3; hi++) begin
                  run_trial(bm[0], (li == 0) ? 0 : (li == 1) ? 2 : (li == 2) ? 3 : 6,
                            (hi == 0) ? 0 : (hi == 1) ? 1 : 4, 0, s);
                  s++;
               end
      end

      // R9: missing marker on first read, stray marker on read 3
      run_trial(1'b0, 3, 2, 1, 40);
      run_trial(1'b1, 4, 2, 1, 41);
      run_trial(1'b0, 3, 2, 2, 42);
      run_trial(1'b1, 5, 1, 2, 43);

      // R3: a start during an active read frame is discarded
      @(negedge clk);
      cur_seed = 50; err_mode = 0; attempts = 0; got = 0; nerr = 0; exp_ch = 0;
      byte_mode = 1'b0; rd_low_cyc = 8'd3; rd_high_cyc = 8'd1; exp_lo = 3; exp_hi = 1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (adc_cs_n) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!adc_cs_n) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(got == 8 && adc_cs_n == 1'b1 && adc_convst_a == 1'b0,
          "R3 start during frame discarded", got, 8);

      finish_run();
   end

endmodule